// File: doc/BRIEF.md
# Slot Frame Dispatcher

This block sits on the serial port of one converter in a daisy chain, after configuration has finished. It shifts in 16-bit frames, MSB first, each marked by a one-cycle frame sync on the first bit. It counts frame syncs to find the frame in its own chain slot. What it does with that frame depends on the held operating mode. In plain data mode the whole frame goes to the DAC register. In mixed mode the top bit of the frame separates DAC samples from control words. Mixed-mode DAC samples are shifted up one place with a zero appended. Control words are passed out on their own strobe.

On the output side, a strobe with a parallel ADC sample starts a 16-bit serial frame. In mixed mode the top bit of that frame is cleared. A loopback mode replaces this output with the serial input delayed by exactly one frame length. Mode and slot-count writes are refused for good once plain data mode is entered, until reset. Loopback can be switched off only while mixed mode is held. Every serial bit is one cycle of `clk`.

Top module: `slot_frame_dispatch`

## Requirements
- R1: After reset the held mode is program mode with loopback off and a slot count of 1. `dac_load`, `ctl_valid`, `sdo_fs` and `sdo` are all low.
- R2: In program mode (held `dp`=0) received frames raise neither `dac_load` nor `ctl_valid`.
- R3: In data mode (`dp`=1, `mm`=0), the frame in this device's slot is copied unchanged to `dac_data`. `dac_load` is high for exactly one cycle: the cycle after the edge that samples the frame's 16th bit.
- R4: Each frame sync moves the slot position 1, 2, … up to the effective count and then back to 1. Only the frame whose position equals the count is taken. A count field of 0 means 2^CNT_W, which is 8 by default. Any accepted configuration write restarts the position.
- R5: While data mode is held, every `mode_wr` and `cnt_wr` is ignored until reset. In program and mixed mode both writes take effect at the next edge.
- R6: In mixed mode (`dp`=1, `mm`=1), a selected frame with bit 15 clear loads `dac_data` = frame bits 14..0 followed by a 0 in bit 0.
- R7: In mixed mode, a selected frame with bit 15 set gives a one-cycle `ctl_valid` with `ctl_word` = frame bits 14..0, and no `dac_load`.
- R8: An `adc_strobe` while the transmitter is idle starts a frame in the next cycle. `sdo_fs` is high only with the first bit, and the bits follow MSB first on 16 consecutive cycles. Bit 15 is forced to 0 when mixed mode is held. A strobe during a frame is ignored.
- R9: With loopback on, `sdo_fs`/`sdo` equal `sdi_fs`/`sdi` from 16 cycles earlier, and ADC strobes have no effect on the output.
- R10: A `mode_wr` clears loopback only if mixed mode is held when the write arrives. Otherwise loopback stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode fields |
| mode_dp | input | 1 | Data (1) or program (0) selector |
| mode_mm | input | 1 | Mixed-mode selector, used when `mode_dp` is 1 |
| mode_dlb | input | 1 | Loopback request |
| cnt_wr | input | 1 | Write strobe for the slot count |
| cnt_val | input | CNT_W | Slot count, 0 meaning 2^CNT_W |
| sdi_fs | input | 1 | Input frame sync, high with the first bit |
| sdi | input | 1 | Serial input data, MSB first |
| adc_strobe | input | 1 | Starts transmission of `adc_data` |
| adc_data | input | FRAME_W | Parallel ADC sample |
| dac_load | output | 1 | One-cycle DAC register load |
| dac_data | output | FRAME_W | DAC register value |
| ctl_valid | output | 1 | One-cycle control word strobe |
| ctl_word | output | FRAME_W-1 | Control word payload |
| sdo_fs | output | 1 | Output frame sync |
| sdo | output | 1 | Serial output data |

## Verification
`dac_load` and `ctl_valid` are due in the cycle after the edge that takes a frame's last bit. Counting from the cycle in which the frame sync is driven, that is 16 cycles later. The bench drives each bit on a falling edge and reads the result on the 16th falling edge after the sync. It reads once more one cycle later to confirm the strobe has dropped. A transmitted frame's first bit appears one cycle after the strobe edge, so the bench collects 16 successive falling-edge samples starting there. Loopback output is compared at every falling edge against the input driven 16 falling edges earlier. Configuration writes take effect at the edge that samples them, so each write is followed by a frame whose outcome shows whether it landed.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef enum logic [1:0] {
    MODE_PGM   = 2'd0,
    MODE_DATA  = 2'd1,
    MODE_MIXED = 2'd2
  } sfd_mode_e;

  function automatic sfd_mode_e decode_mode(input logic dp, input logic mm);
    if (!dp)     return MODE_PGM;
    else if (mm) return MODE_MIXED;
    else         return MODE_DATA;
  endfunction

endpackage

// File: rtl/sfd_mode_reg.sv
module sfd_mode_reg
  import sfd_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int DEF_CNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic             mode_dp,
  input  logic             mode_mm,
  input  logic             mode_dlb,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output sfd_mode_e        cur_mode,
  output logic             dlb_on,
  output logic [CNT_W-1:0] dev_cnt,
  output logic             cfg_accept
);

  sfd_mode_e        mode_q;
  logic             dlb_q;
  logic [CNT_W-1:0] cnt_q;
  logic             locked;

  assign locked     = (mode_q == MODE_DATA);
  assign cfg_accept = (mode_wr || cnt_wr) && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PGM;
      dlb_q  <= 1'b0;
      cnt_q  <= CNT_W'(DEF_CNT);
    end else if (!locked) begin
      if (mode_wr) begin
        mode_q <= decode_mode(mode_dp, mode_mm);
        // clearing loopback is only honoured from mixed mode
        dlb_q  <= mode_dlb || (dlb_q && (mode_q != MODE_MIXED));
      end
      if (cnt_wr) cnt_q <= cnt_val;
    end
  end

  assign cur_mode = mode_q;
  assign dlb_on   = dlb_q;
  assign dev_cnt  = cnt_q;

endmodule

// File: rtl/sfd_slot_ctr.sv
module sfd_slot_ctr #(
  parameter int CNT_W = 3,
  localparam int SLOT_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              enable,
  input  logic              frame_start,
  input  logic [CNT_W-1:0]  dev_cnt,
  output logic [SLOT_W-1:0] slot,
  output logic              mine
);

  function automatic logic [SLOT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    if (c == '0) return SLOT_W'(1 << CNT_W);
    else         return SLOT_W'(c);
  endfunction

  function automatic logic [SLOT_W-1:0] step_slot(input logic [SLOT_W-1:0] s,
                                                  input logic [SLOT_W-1:0] lim);
    if (s >= lim) return SLOT_W'(1);
    else          return s + SLOT_W'(1);
  endfunction

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] limit;
  logic [SLOT_W-1:0] slot_nxt;
  logic              mine_q;

  assign limit    = eff_count(dev_cnt);
  assign slot_nxt = step_slot(slot_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      mine_q <= 1'b0;
    end else if (clear) begin
      slot_q <= '0;
      mine_q <= 1'b0;
    end else if (frame_start && enable) begin
      slot_q <= slot_nxt;
      mine_q <= (slot_nxt == limit);
    end
  end

  assign slot = slot_q;
  assign mine = mine_q;

endmodule

// File: rtl/sfd_frame_rx.sv
module sfd_frame_rx #(
  parameter int FRAME_W = 16,
  localparam int BC_W = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi_fs,
  input  logic               sdi,
  output logic               rx_done,
  output logic [FRAME_W-1:0] rx_word
);

  logic [FRAME_W-2:0] sh_q;
  logic [BC_W-1:0]    bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (sdi_fs) begin
      sh_q  <= {sh_q[FRAME_W-3:0], sdi};
      bit_q <= BC_W'(1);
    end else if (bit_q != '0) begin
      sh_q  <= {sh_q[FRAME_W-3:0], sdi};
      bit_q <= (bit_q == BC_W'(FRAME_W-1)) ? '0 : bit_q + BC_W'(1);
    end
  end

  // last bit is on sdi during the cycle in which the counter reads FRAME_W-1
  assign rx_done = (bit_q == BC_W'(FRAME_W-1));
  assign rx_word = {sh_q, sdi};

endmodule

// File: rtl/sfd_frame_tx.sv
module sfd_frame_tx #(
  parameter int FRAME_W = 16,
  localparam int LEFT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               tx_fs,
  output logic               tx_sd
);

  logic [FRAME_W-1:0] sh_q;
  logic [LEFT_W-1:0]  left_q;
  logic               fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      fs_q   <= 1'b0;
    end else if (start && left_q == '0) begin
      sh_q   <= word;
      left_q <= LEFT_W'(FRAME_W);
      fs_q   <= 1'b1;
    end else if (left_q != '0) begin
      sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
      left_q <= left_q - LEFT_W'(1);
      fs_q   <= 1'b0;
    end
  end

  assign tx_fs = fs_q;
  assign tx_sd = (left_q != '0) && sh_q[FRAME_W-1];

endmodule

// File: rtl/sfd_echo_line.sv
module sfd_echo_line #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_fs,
  input  logic in_sd,
  output logic out_fs,
  output logic out_sd
);

  logic [1:0] stage [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= {in_fs, in_sd};
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign out_fs = stage[DEPTH-1][1];
  assign out_sd = stage[DEPTH-1][0];

endmodule

// File: rtl/slot_frame_dispatch.sv
module slot_frame_dispatch
  import sfd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic               mode_dp,
  input  logic               mode_mm,
  input  logic               mode_dlb,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               sdi_fs,
  input  logic               sdi,
  input  logic               adc_strobe,
  input  logic [FRAME_W-1:0] adc_data,
  output logic               dac_load,
  output logic [FRAME_W-1:0] dac_data,
  output logic               ctl_valid,
  output logic [FRAME_W-2:0] ctl_word,
  output logic               sdo_fs,
  output logic               sdo
);

  localparam int SLOT_W = CNT_W + 1;

  function automatic logic [FRAME_W-1:0] rejustify(input logic [FRAME_W-1:0] w);
    return {w[FRAME_W-2:0], 1'b0};
  endfunction

  function automatic logic [FRAME_W-1:0] mark_sample(input logic [FRAME_W-1:0] w);
    return {1'b0, w[FRAME_W-2:0]};
  endfunction

  sfd_mode_e          cur_mode;
  logic               dlb_on;
  logic [CNT_W-1:0]   dev_cnt;
  logic               cfg_accept;
  logic [SLOT_W-1:0]  slot;
  logic               slot_mine;
  logic               rx_done;
  logic [FRAME_W-1:0] rx_word;
  logic               tx_start;
  logic [FRAME_W-1:0] tx_word;
  logic               tx_fs, tx_sd, echo_fs, echo_sd;
  logic               take_frame;

  sfd_mode_reg #(.CNT_W(CNT_W), .DEF_CNT(1)) mode_i (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(mode_wr), .mode_dp(mode_dp), .mode_mm(mode_mm), .mode_dlb(mode_dlb),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .cur_mode(cur_mode), .dlb_on(dlb_on), .dev_cnt(dev_cnt), .cfg_accept(cfg_accept)
  );

  sfd_slot_ctr #(.CNT_W(CNT_W)) slot_i (
    .clk(clk), .rst_n(rst_n),
    .clear(cfg_accept), .enable(cur_mode != MODE_PGM), .frame_start(sdi_fs),
    .dev_cnt(dev_cnt), .slot(slot), .mine(slot_mine)
  );

  sfd_frame_rx #(.FRAME_W(FRAME_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .sdi_fs(sdi_fs), .sdi(sdi),
    .rx_done(rx_done), .rx_word(rx_word)
  );

  assign take_frame = rx_done && slot_mine;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_load  <= 1'b0;
      dac_data  <= '0;
      ctl_valid <= 1'b0;
      ctl_word  <= '0;
    end else begin
      dac_load  <= 1'b0;
      ctl_valid <= 1'b0;
      if (take_frame) begin
        unique case (cur_mode)
          MODE_DATA: begin
            dac_load <= 1'b1;
            dac_data <= rx_word;
          end
          MODE_MIXED: begin
            if (rx_word[FRAME_W-1]) begin
              ctl_valid <= 1'b1;
              ctl_word  <= rx_word[FRAME_W-2:0];
            end else begin
              dac_load  <= 1'b1;
              dac_data  <= rejustify(rx_word);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_start = adc_strobe && !dlb_on;
  assign tx_word  = (cur_mode == MODE_MIXED) ? mark_sample(adc_data) : adc_data;

  sfd_frame_tx #(.FRAME_W(FRAME_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .word(tx_word),
    .tx_fs(tx_fs), .tx_sd(tx_sd)
  );

  sfd_echo_line #(.DEPTH(FRAME_W)) echo_i (
    .clk(clk), .rst_n(rst_n), .in_fs(sdi_fs), .in_sd(sdi),
    .out_fs(echo_fs), .out_sd(echo_sd)
  );

  assign sdo_fs = dlb_on ? echo_fs : tx_fs;
  assign sdo    = dlb_on ? echo_sd : tx_sd;

endmodule

// File: rtl/slot_frame_dispatch_chk.sv
module slot_frame_dispatch_chk
  import sfd_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input sfd_mode_e          cur_mode,
  input logic [CNT_W-1:0]   dev_cnt,
  input logic [CNT_W:0]     slot,
  input logic               dlb_on,
  input logic               rx_done,
  input logic               dac_load,
  input logic [FRAME_W-1:0] dac_data,
  input logic               ctl_valid
);

  logic [CNT_W:0] top_slot;
  assign top_slot = (dev_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, dev_cnt};

  AST_PGM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_load || ctl_valid) |-> $past(cur_mode) != MODE_PGM); // R2
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> !dac_load); // R3
  AST_LOAD_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> $past(rx_done)); // R3
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= top_slot); // R4
  AST_DATA_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_DATA) |=> (cur_mode == MODE_DATA) && $stable(dev_cnt)); // R5
  AST_MIXED_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_load && $past(cur_mode) == MODE_MIXED) |-> !dac_data[0]); // R6
  AST_CTL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !ctl_valid); // R7
  AST_CTL_ONLY_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> $past(cur_mode) == MODE_MIXED && !dac_load); // R7
  AST_DLB_EXIT_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dlb_on) |-> $past(cur_mode) == MODE_MIXED); // R10

endmodule

bind slot_frame_dispatch slot_frame_dispatch_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .dev_cnt(dev_cnt), .slot(slot),
  .dlb_on(dlb_on), .rx_done(rx_done), .dac_load(dac_load), .dac_data(dac_data),
  .ctl_valid(ctl_valid)
);

// File: tb/slot_frame_dispatch_tb_top.sv
module slot_frame_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0, mode_dp = 1'b0, mode_mm = 1'b0, mode_dlb = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [2:0]  cnt_val = '0;
  logic        sdi_fs = 1'b0, sdi = 1'b0;
  logic        adc_strobe = 1'b0;
  logic [15:0] adc_data = '0;
  logic        dac_load, ctl_valid, sdo_fs, sdo;
  logic [15:0] dac_data;
  logic [14:0] ctl_word;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  slot_frame_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_dp(mode_dp), .mode_mm(mode_mm),
    .mode_dlb(mode_dlb), .cnt_wr(cnt_wr), .cnt_val(cnt_val), .sdi_fs(sdi_fs), .sdi(sdi),
    .adc_strobe(adc_strobe), .adc_data(adc_data), .dac_load(dac_load), .dac_data(dac_data),
    .ctl_valid(ctl_valid), .ctl_word(ctl_word), .sdo_fs(sdo_fs), .sdo(sdo)
  );

  // {frame, kind (1 = DAC load, 2 = control word), expected value}
  localparam logic [33:0] VEC [7] = '{
    {16'h1234, 2'd1, 16'h2468},
    {16'h7FFF, 2'd1, 16'hFFFE},
    {16'h0000, 2'd1, 16'h0000},
    {16'h4001, 2'd1, 16'h8002},
    {16'h8001, 2'd2, 16'h0001},
    {16'hFFFF, 2'd2, 16'h7FFF},
    {16'hC5A3, 2'd2, 16'h45A3}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mode_wr = 0; cnt_wr = 0; sdi_fs = 0; sdi = 0; adc_strobe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_mode(input logic dp, input logic mm, input logic dlb);
    @(negedge clk);
    mode_wr = 1; mode_dp = dp; mode_mm = mm; mode_dlb = dlb;
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic wr_cnt(input logic [2:0] v);
    @(negedge clk);
    cnt_wr = 1; cnt_val = v;
    @(negedge clk);
    cnt_wr = 0;
  endtask

  task automatic send_frame(input logic [15:0] f, output logic ld, output logic ct,
                            output logic [15:0] dd, output logic [14:0] cw,
                            output logic tail);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sdi_fs = (i == 0);
      sdi    = f[15-i];
    end
    @(negedge clk);
    sdi_fs = 0; sdi = 0;
    ld = dac_load; ct = ctl_valid; dd = dac_data; cw = ctl_word;
    @(negedge clk);
    tail = dac_load | ctl_valid;
  endtask

  task automatic tx_run(input logic [15:0] w, input logic mid, output logic [15:0] got,
                        output int fs_hits, output logic fs_first, output logic idle);
    @(negedge clk);
    adc_strobe = 1; adc_data = w;
    @(negedge clk);
    adc_strobe = 0;
    fs_first = sdo_fs; got = '0; fs_hits = 0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      got = {got[14:0], sdo};
      fs_hits += int'(sdo_fs);
      if (mid && k == 5) begin adc_strobe = 1; adc_data = ~w; end
      if (mid && k == 6) adc_strobe = 0;
    end
    @(negedge clk);
    idle = !sdo_fs && !sdo;
  endtask

  task automatic run_echo(input int n, input string tag);
    logic hf [64];
    logic hd [64];
    int   bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i >= 16 && (sdo_fs !== hf[i-16] || sdo !== hd[i-16])) bad++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      hf[i] = (i % 7 == 3);
      hd[i] = lf[0];
      sdi_fs = hf[i]; sdi = hd[i];
      adc_strobe = (i == 20); adc_data = 16'hFFFF;
    end
    @(negedge clk);
    sdi_fs = 0; sdi = 0; adc_strobe = 0;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic ld, ct, tail, fs_first, idle;
    logic [15:0] dd, got;
    logic [14:0] cw;
    int fs_hits;

    // R1 reset state
    do_reset();
    chk(!dac_load && !ctl_valid && !sdo_fs && !sdo, "R1 outputs low after reset",
        {dac_load, ctl_valid, sdo_fs, sdo}, 0);

    // R2 program mode ignores frames
    send_frame(16'h1234, ld, ct, dd, cw, tail);
    chk(!ld && !ct, "R2 no load or ctl in program mode", {ld, ct}, 0);

    // R1 default count of 1, R3 data mode whole-frame loads
    wr_mode(1, 0, 0);
    send_frame(16'hABCD, ld, ct, dd, cw, tail);
    chk(ld && !ct && dd == 16'hABCD, "R3 data load first frame (R1 count 1)", {ld, ct, dd}, {2'b10, 16'hABCD});
    chk(!tail, "R3 load lasts one cycle", tail, 0);
    send_frame(16'h8001, ld, ct, dd, cw, tail);
    chk(ld && !ct && dd == 16'h8001, "R3 MSB set still data in data mode", {ld, ct, dd}, {2'b10, 16'h8001});

    // R5 writes ignored in data mode
    wr_mode(0, 0, 0);
    wr_cnt(3'd2);
    send_frame(16'h5555, ld, ct, dd, cw, tail);
    chk(ld && dd == 16'h5555, "R5 mode and count locked in data mode", {ld, dd}, {1'b1, 16'h5555});

    // R4 slot counting with count 3
    do_reset();
    wr_cnt(3'd3);
    wr_mode(1, 0, 0);
    for (int k = 1; k <= 6; k++) begin
      send_frame(16'h0100 + 16'(k), ld, ct, dd, cw, tail);
      chk(ld == (k % 3 == 0), "R4 slot select with count 3", ld, (k % 3 == 0));
      if (k % 3 == 0) chk(dd == 16'h0100 + 16'(k), "R3 slot frame data", dd, 16'h0100 + 16'(k));
    end

    // R6 R7 mixed mode vectors
    do_reset();
    wr_mode(1, 1, 0);
    for (int v = 0; v < 7; v++) begin
      send_frame(VEC[v][33:18], ld, ct, dd, cw, tail);
      if (VEC[v][17:16] == 2'd1)
        chk(ld && !ct && dd == VEC[v][15:0], "R6 mixed DAC rejustified", {ld, ct, dd}, {2'b10, VEC[v][15:0]});
      else
        chk(ct && !ld && cw == VEC[v][14:0], "R7 mixed control word", {ld, ct, 1'b0, cw}, {2'b01, 1'b0, VEC[v][14:0]});
      chk(!tail, "R7 strobe lasts one cycle", tail, 0);
    end

    // R4 count 0 means 8; R5 writes accepted in mixed mode
    wr_cnt(3'd0);
    for (int k = 1; k <= 9; k++) begin
      send_frame(16'h0011, ld, ct, dd, cw, tail);
      chk(ld == (k == 8), "R4 count 0 acts as 8", ld, (k == 8));
    end
    wr_cnt(3'd2);
    send_frame(16'h0011, ld, ct, dd, cw, tail);
    chk(!ld, "R5 mixed count write restarts slot", ld, 0);
    send_frame(16'h0011, ld, ct, dd, cw, tail);
    chk(ld && dd == 16'h0022, "R5 mixed count write taken", {ld, dd}, {1'b1, 16'h0022});

    // R8 transmit in mixed mode, mid-frame strobe ignored
    tx_run(16'hF0F0, 1'b1, got, fs_hits, fs_first, idle);
    chk(got == 16'h70F0, "R8 mixed ADC frame MSB cleared", got, 16'h70F0);
    chk(fs_first && fs_hits == 1, "R8 sync only on first bit", fs_hits, 1);
    chk(idle, "R8 strobe during frame ignored", idle, 1);

    // R8 transmit in program mode unmarked
    do_reset();
    tx_run(16'hF0F0, 1'b0, got, fs_hits, fs_first, idle);
    chk(got == 16'hF0F0 && fs_first, "R8 program ADC frame unchanged", got, 16'hF0F0);

    // R9 loopback, R10 clear refused outside mixed mode
    do_reset();
    wr_mode(0, 0, 1);
    run_echo(60, "R9 loopback echoes 16 cycles later");
    wr_mode(0, 0, 0);
    run_echo(40, "R10 loopback kept outside mixed mode");
    wr_mode(1, 1, 1);
    wr_mode(1, 1, 0);
    tx_run(16'h9234, 1'b0, got, fs_hits, fs_first, idle);
    chk(got == 16'h1234 && fs_first, "R10 loopback cleared from mixed mode", got, 16'h1234);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule